// File: doc/BRIEF.md
# Reference-Based Frequency Lock Monitor

This block watches a clock recovery loop and tells the rest of the chip whether the loop has locked. Two slow clocks arrive from outside the sampling domain. The first is a reference clock. The second is the recovered full-rate clock after a divide-by-32 stage placed upstream. Each clock passes through a two-flop synchroniser, and its rising edges are counted on the sampling clock.

A measurement window spans a fixed number of reference rising edges. When the window closes, the block compares the number of recovered-clock edges seen in it with a tolerance band around the nominal count. With the defaults, the band is 4096 ± 4 counts, which is roughly ±1000 ppm. Both counters then restart.

The alarm output is high while the loop is out of lock. A single window outside the band sets the alarm. The alarm clears only after two windows in a row fall inside the band. Reset sets the alarm, so the loop starts out reported as unlocked.

Top module: `freq_lock_monitor`

## Requirements
- R1: `lol_o` is 1 when the loop is out of lock and 0 when it is locked.
- R2: Each clock input is synchronised through two flip-flops and counted on its rising edges. An input level must be held for at least two sampling cycles to be counted.
- R3: A window closes on reference rising edge number `WIN_EDGES`, counted from reset or from the previous close. The recovered edges counted for that window include any edge detected in the same sampling cycle as the closing edge.
- R4: A window is in tolerance exactly when its recovered-edge count lies in [`WIN_EDGES`-`TOL_COUNTS`, `WIN_EDGES`+`TOL_COUNTS`]. The defaults are 4096 and 4.
- R5: A single out-of-tolerance window sets `lol_o` to 1 and clears any pending in-tolerance credit. This includes a window with no recovered edges.
- R6: From the out-of-lock state, `lol_o` falls only after two consecutive in-tolerance windows. One in-tolerance window followed by an out-of-tolerance window leaves `lol_o` at 1.
- R7: `lol_o` changes only when a window closes, and is constant between closes.
- R8: Reset sets `lol_o` to 1 and clears both counters and the in-tolerance credit.
- R9: The recovered-edge count saturates just above the band instead of wrapping. A recovered clock far too fast is therefore always reported out of tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk` |
| rec_div_i | input | 1 | Recovered clock divided by 32, asynchronous to `clk` |
| lol_o | output | 1 | Loss-of-lock alarm, 1 = not locked |

## Verification
The hardest situation to bring about from the ports is a recovered-edge count that sits exactly on a band edge, or one count outside it, in a known window. Synchroniser latency and free-running clocks blur which window an edge lands in. To get around this, the bench derives both input clocks from the sampling clock itself. The reference has a fixed 8-cycle period. The recovered clock comes from a phase accumulator that yields exactly N rising edges in any run of one window's worth of cycles, and N is changed only on window boundaries. This lets directed counts of WIN±TOL and WIN±(TOL+1) be mixed with random counts around nominal, while every window's count stays exact.

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor #(
  parameter int WIN_EDGES   = 4096,
  parameter int TOL_COUNTS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk_i,
  input  logic rec_div_i,
  output logic lol_o
);
  localparam int RW      = $clog2(WIN_EDGES);
  localparam int REC_MAX = WIN_EDGES + TOL_COUNTS + 1;
  localparam int CW      = $clog2(REC_MAX + 1);
  localparam int LO      = WIN_EDGES - TOL_COUNTS;
  localparam int HI      = WIN_EDGES + TOL_COUNTS;

  logic [SYNC_STAGES:0] ref_sh, rec_sh;
  logic [RW-1:0]        ref_cnt;
  logic [CW-1:0]        rec_cnt, rec_now;
  logic                 good_once;
  logic                 ref_rise, rec_rise, win_end, in_tol;

  assign ref_rise = ref_sh[SYNC_STAGES-1] & ~ref_sh[SYNC_STAGES];
  assign rec_rise = rec_sh[SYNC_STAGES-1] & ~rec_sh[SYNC_STAGES];
  assign win_end  = ref_rise && (ref_cnt == RW'(WIN_EDGES - 1));
  assign rec_now  = (rec_rise && rec_cnt != CW'(REC_MAX)) ? rec_cnt + 1'b1 : rec_cnt;
  assign in_tol   = (rec_now >= CW'(LO)) && (rec_now <= CW'(HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sh    <= '0;
      rec_sh    <= '0;
      ref_cnt   <= '0;
      rec_cnt   <= '0;
      good_once <= 1'b0;
      lol_o     <= 1'b1;
    end else begin
      ref_sh <= {ref_sh[SYNC_STAGES-1:0], ref_clk_i};
      rec_sh <= {rec_sh[SYNC_STAGES-1:0], rec_div_i};
      if (win_end) begin
        ref_cnt <= '0;
        rec_cnt <= '0;
        if (in_tol) begin
          if (good_once) lol_o <= 1'b0;
          good_once <= 1'b1;
        end else begin
          lol_o     <= 1'b1;
          good_once <= 1'b0;
        end
      end else begin
        if (ref_rise) ref_cnt <= ref_cnt + 1'b1;
        rec_cnt <= rec_now;
      end
    end
  end
endmodule

module freq_lock_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic lol_o,
  input logic win_end,
  input logic in_tol
);
  a_r8_reset_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> lol_o);
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(lol_o));
  a_r5_fail_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !in_tol) |=> lol_o);
  a_r6_fall_needs_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lol_o) |-> $past(win_end && in_tol));
  a_r1_rise_needs_fail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lol_o) |-> $past(win_end && !in_tol));
endmodule

bind freq_lock_monitor freq_lock_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lol_o(lol_o), .win_end(win_end), .in_tol(in_tol)
);

// File: tb/freq_lock_monitor_bench.sv
module freq_lock_monitor_bench;
  localparam int WIN  = 256;
  localparam int TOL  = 4;
  localparam int RP   = 8;
  localparam int SPAN = WIN * RP;

  logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, rec_clk = 1'b0;
  wire  lol;
  int   n_cmp = 0, n_bad = 0;
  int   cyc, acc, hold;
  bit   m_lol, m_good, done = 0;

  always #5 clk = ~clk;

  freq_lock_monitor #(.WIN_EDGES(WIN), .TOL_COUNTS(TOL)) u_freq_lock_monitor (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .rec_div_i(rec_clk), .lol_o(lol));

  function automatic bit in_band(int n);
    return (n >= WIN - TOL) && (n <= WIN + TOL);
  endfunction

  task automatic check(input bit exp, input string tag);
    n_cmp++;
    if (lol !== exp) begin
      n_bad++;
      $display("FAIL %s: lol_o=%b expected=%b (cycle %0d)", tag, lol, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    @(negedge clk);
    cyc++;
    acc += n;
    if (acc >= SPAN) begin acc -= SPAN; hold = 2; end
    rec_clk = (hold > 0);
    if (hold > 0) hold--;
    ref_clk = (cyc >= RP) && ((cyc % RP) < RP / 2);
  endtask

  task automatic model(input int n);
    if (!in_band(n)) begin m_lol = 1; m_good = 0; end
    else begin
      if (m_good) m_lol = 0;
      m_good = 1;
    end
  endtask

  task automatic run_window(input int n, input string tag);
    for (int i = 1; i <= SPAN; i++) begin
      step(n);
      if (i == SPAN / 2 || i == SPAN - 8) check(m_lol, tag);
    end
    model(n);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ref_clk = 0; rec_clk = 0;
    cyc = -1; acc = 0; hold = 0; m_lol = 1; m_good = 0;
    repeat (3) @(negedge clk);
    check(1'b1, "R8 reset");
    rst_n = 1;
    step(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: lol_o=%b expected=finished", lol);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    do_reset();
    run_window(WIN, "R6 first pass keeps alarm");
    run_window(WIN, "R1,R6 second pass locks");
    run_window(WIN + TOL, "R4 upper edge in band");
    run_window(WIN + TOL + 1, "R4,R5 one over band");
    run_window(WIN - TOL, "R4,R6 lower edge single pass");
    run_window(WIN - TOL - 1, "R5,R6 credit cleared");
    run_window(WIN - TOL, "R6 restart credit");
    run_window(WIN, "R6 relock");
    run_window(0, "R5 no recovered edges");
    run_window(600, "R9 far too fast");
    run_window(WIN, "R2,R3 recovery pass");
    run_window(WIN, "R3 relock");
    for (int k = 0; k < 12; k++) begin
      int n = WIN - 10 + int'($urandom % 21);
      run_window(n, "R4,R7 random count");
    end
    do_reset();
    run_window(WIN, "R8 credit cleared by reset");
    run_window(WIN, "R6 lock after reset");
    run_window(WIN - 1, "R7 stays locked");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule